// File: doc/BRIEF.md
# Shift and Rotate-Under-Mask Unit

A purely combinational 64-bit integer execution unit. A single datapath handles four kinds of work. It does logical left shifts. It does logical and arithmetic right shifts. It sign-extends the low word and then shifts it left. It rotates left and then applies a mask, either merging the rotated value into a second operand or clearing everything outside the mask. A word-mode flag picks 32-bit behaviour for the shifts, and a signed flag picks the arithmetic form of the right shift.

Masks count bits from the most significant end: position 0 is bit 63. A mask is given by a begin position and an end position. If begin is greater than end, the mask wraps around.

The unit has no state and no handshake. An issuing pipeline stage presents the operands and samples the result in the same cycle. An opaque context word and a small routing tag ride alongside the operands and come out unchanged.

Top module: `srm_unit`

## Requirements
- R1: Op code 1 is left shift. In word mode the amount is rb[5:0], the result is bits 31:0 of rs shifted left, and bits 63:32 are zero. Otherwise the amount is rb[6:0], and any amount of 64 or more gives zero.
- R2: Op code 2 with the signed flag low is logical right shift. In word mode rs[31:0] is shifted right by rb[5:0] and the result is zero-extended. Otherwise all of rs is shifted right by rb[6:0].
- R3: Op code 2 with the signed flag high is arithmetic right shift, filled with the sign bit. In word mode the operand is rs[31:0], the amount is rb[5:0], and the result is sign-extended through bit 63. Otherwise the amount is rb[6:0], and 64 or more gives all sign bits.
- R4: For the arithmetic right shift, both carry bits equal 1 exactly when the operand is negative and at least one 1 bit is shifted out. Every other operation drives the carry pair to 0.
- R5: Mask position p maps to result bit 63-p. If begin is at most end, the mask holds ones from begin to end inclusive. If begin is greater than end, the mask holds ones everywhere except positions end+1 to begin-1.
- R6: Op code 4 is word rotate. It copies rs[31:0] into both halves, rotates left by rb[4:0], and uses mask begin mb[4:0]+32 and end me[4:0]+32. The result is (rot & mask) | (ra & ~mask).
- R7: Op code 5 is doubleword rotate-insert. It rotates rs left by k=rb[5:0] and uses mask begin {mb[0],mb[5:1]} and end 63-k. The result is (rot & mask) | (ra & ~mask).
- R8: Op code 6 is doubleword rotate-clear. It rotates rs left by rb[5:0] and uses mask begin {mb[0],mb[5:1]} and end 63. The result is rot & mask, and ra has no effect.
- R9: Op code 3 sign-extends rs[31:0] to 64 bits, shifts it left by rb[5:0], and keeps 64 bits.
- R10: The context and tag outputs always equal the context and tag inputs.
- R11: The valid output is 1 for op codes 1 to 6. For op codes 0 and 7 it is 0, and the result and carry pair are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 3 | Operation code (see requirements) |
| word_mode_i | input | 1 | Selects 32-bit behaviour for the shift operations |
| signed_i | input | 1 | Selects arithmetic right shift |
| rs_i | input | 64 | Value to be shifted or rotated |
| rb_i | input | 7 | Shift or rotate amount |
| ra_i | input | 64 | Operand merged outside the mask |
| mb_i | input | 6 | Mask begin field |
| me_i | input | 5 | Mask end field (word rotate) |
| ctx_i | input | 8 | Opaque operation context |
| tag_i | input | 2 | Routing tag |
| res_o | output | 64 | Result |
| res_valid_o | output | 1 | Op code is supported |
| carry_o | output | 2 | Carry pair |
| ctx_o | output | 8 | Context, passed through |
| tag_o | output | 2 | Tag, passed through |

## Verification
Two situations are hard to reach from the ports.

The first is the arithmetic-shift carry when a single 1 bit sits just below the shift boundary. A value that is nearly all zeros looks like a case where nothing is lost, yet it must still raise the carry. The stimulus reaches this with operands whose only set low bits are bit 0 or bit 31. These operands are crossed with amounts on both sides of 32 and 64, in both widths.

The second is the wraparound mask edge, where begin is exactly one past end and the mask turns all ones. This is covered by sweeping every begin/end pair of the word rotate and every begin of the rotate-clear with an all-ones source, so that the result shows the raw mask.

// File: rtl/srm_pkg.sv
package srm_pkg;

  typedef enum logic [2:0] {
    OP_NONE   = 3'd0,
    OP_SHL    = 3'd1,
    OP_SHR    = 3'd2,
    OP_EXTSH  = 3'd3,
    OP_ROT32  = 3'd4,
    OP_ROTINS = 3'd5,
    OP_ROTCLR = 3'd6,
    OP_RSVD   = 3'd7
  } srm_op_e;

  function automatic logic op_supported(input srm_op_e op);
    return (op != OP_NONE) && (op != OP_RSVD);
  endfunction

endpackage

// File: rtl/srm_barrel.sv
// Logarithmic shifter: one stage per amount bit, fill bit shifted in.
module srm_barrel #(
  parameter int W       = 64,
  parameter int AW      = $clog2(W),
  parameter bit TO_LEFT = 1'b1
) (
  input  logic [W-1:0]  din_i,
  input  logic [AW-1:0] amt_i,
  input  logic          fill_i,
  output logic [W-1:0]  dout_o
);
  logic [W-1:0] st [0:AW];
  assign st[0] = din_i;

  for (genvar s = 0; s < AW; s++) begin : g_stage
    localparam int D = 1 << s;
    if (TO_LEFT) begin : g_left
      assign st[s+1] = amt_i[s] ? {st[s][W-1-D:0], {D{fill_i}}} : st[s];
    end else begin : g_right
      assign st[s+1] = amt_i[s] ? {{D{fill_i}}, st[s][W-1:D]} : st[s];
    end
  end

  assign dout_o = st[AW];
endmodule

// File: rtl/srm_rotl.sv
// Logarithmic left rotator.
module srm_rotl #(
  parameter int W  = 64,
  parameter int AW = $clog2(W)
) (
  input  logic [W-1:0]  din_i,
  input  logic [AW-1:0] amt_i,
  output logic [W-1:0]  dout_o
);
  logic [W-1:0] st [0:AW];
  assign st[0] = din_i;

  for (genvar s = 0; s < AW; s++) begin : g_stage
    localparam int D = 1 << s;
    assign st[s+1] = amt_i[s] ? {st[s][W-1-D:0], st[s][W-1:W-D]} : st[s];
  end

  assign dout_o = st[AW];
endmodule

// File: rtl/srm_mask_gen.sv
// Big-endian numbered mask with wraparound when first > last.
module srm_mask_gen #(
  parameter int W  = 64,
  parameter int IW = $clog2(W)
) (
  input  logic [IW-1:0] first_i,
  input  logic [IW-1:0] last_i,
  output logic [W-1:0]  mask_o
);
  localparam logic [W-1:0] ONES = '1;

  logic [IW:0]  last_p1;
  logic [W-1:0] from_first;
  logic [W-1:0] upto_last;

  assign last_p1    = {1'b0, last_i} + 1'b1;
  assign from_first = ONES >> first_i;
  assign upto_last  = ~(ONES >> last_p1);
  assign mask_o     = (first_i <= last_i) ? (from_first & upto_last)
                                          : (from_first | upto_last);
endmodule

// File: rtl/srm_shift_path.sv
// Left shift, sign-extend-then-shift, logical/arithmetic right shift.
module srm_shift_path
  import srm_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int AW    = $clog2(XLEN),
  parameter int AMT_W = AW + 1
) (
  input  srm_op_e          op_i,
  input  logic             word_mode_i,
  input  logic             signed_i,
  input  logic [XLEN-1:0]  rs_i,
  input  logic [AMT_W-1:0] amt_i,
  output logic [XLEN-1:0]  shl_res_o,
  output logic [XLEN-1:0]  ext_res_o,
  output logic [XLEN-1:0]  shr_res_o,
  output logic             sra_carry_o
);
  localparam int HALF = XLEN / 2;
  localparam logic [XLEN-1:0] ONES = '1;

  logic [XLEN-1:0] left_src, lsh;
  logic [XLEN-1:0] shr_opnd, rsh, lost_bits;
  logic            fill, over;

  assign left_src = (op_i == OP_EXTSH) ? {{HALF{rs_i[HALF-1]}}, rs_i[HALF-1:0]}
                                       : rs_i;

  srm_barrel #(.W(XLEN), .AW(AW), .TO_LEFT(1'b1)) u_lsh (
    .din_i (left_src),
    .amt_i (amt_i[AW-1:0]),
    .fill_i(1'b0),
    .dout_o(lsh)
  );

  assign ext_res_o = lsh;
  assign shl_res_o = word_mode_i ? {{HALF{1'b0}}, lsh[HALF-1:0]}
                                 : (amt_i[AW] ? '0 : lsh);

  assign shr_opnd = word_mode_i
                  ? {{HALF{signed_i & rs_i[HALF-1]}}, rs_i[HALF-1:0]}
                  : rs_i;
  assign fill = signed_i & shr_opnd[XLEN-1];
  assign over = ~word_mode_i & amt_i[AW];

  srm_barrel #(.W(XLEN), .AW(AW), .TO_LEFT(1'b0)) u_rsh (
    .din_i (shr_opnd),
    .amt_i (amt_i[AW-1:0]),
    .fill_i(fill),
    .dout_o(rsh)
  );

  assign shr_res_o   = over ? {XLEN{fill}} : rsh;
  assign lost_bits   = over ? shr_opnd : (shr_opnd & ~(ONES << amt_i[AW-1:0]));
  assign sra_carry_o = fill & (|lost_bits);
endmodule

// File: rtl/srm_rot_path.sv
// Rotate-left then mask, with insert or clear.
module srm_rot_path
  import srm_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int AW    = $clog2(XLEN),
  parameter int AMT_W = AW + 1
) (
  input  srm_op_e          op_i,
  input  logic [XLEN-1:0]  rs_i,
  input  logic [XLEN-1:0]  ra_i,
  input  logic [AMT_W-1:0] amt_i,
  input  logic [AW-1:0]    mb_i,
  input  logic [AW-2:0]    me_i,
  output logic [XLEN-1:0]  rot_res_o
);
  localparam int HALF = XLEN / 2;

  logic [XLEN-1:0] rot_src, rot, mask;
  logic [AW-1:0]   k, mfirst, mlast, dw_first;
  logic            is_word;

  assign is_word  = (op_i == OP_ROT32);
  assign rot_src  = is_word ? {rs_i[HALF-1:0], rs_i[HALF-1:0]} : rs_i;
  assign k        = is_word ? {1'b0, amt_i[AW-2:0]} : amt_i[AW-1:0];
  assign dw_first = {mb_i[0], mb_i[AW-1:1]};

  always_comb begin
    unique case (op_i)
      OP_ROT32: begin
        mfirst = {1'b1, mb_i[AW-2:0]};
        mlast  = {1'b1, me_i};
      end
      OP_ROTINS: begin
        mfirst = dw_first;
        mlast  = ~k;
      end
      default: begin
        mfirst = dw_first;
        mlast  = '1;
      end
    endcase
  end

  srm_rotl #(.W(XLEN), .AW(AW)) u_rot (
    .din_i (rot_src),
    .amt_i (k),
    .dout_o(rot)
  );

  srm_mask_gen #(.W(XLEN), .IW(AW)) u_mask (
    .first_i(mfirst),
    .last_i (mlast),
    .mask_o (mask)
  );

  assign rot_res_o = (op_i == OP_ROTCLR) ? (rot & mask)
                                         : ((rot & mask) | (ra_i & ~mask));
endmodule

// File: rtl/srm_unit.sv
module srm_unit
  import srm_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int CTX_W = 8,
  parameter int TAG_W = 2,
  parameter int AW    = $clog2(XLEN),
  parameter int AMT_W = AW + 1
) (
  input  logic [2:0]       op_i,
  input  logic             word_mode_i,
  input  logic             signed_i,
  input  logic [XLEN-1:0]  rs_i,
  input  logic [AMT_W-1:0] rb_i,
  input  logic [XLEN-1:0]  ra_i,
  input  logic [AW-1:0]    mb_i,
  input  logic [AW-2:0]    me_i,
  input  logic [CTX_W-1:0] ctx_i,
  input  logic [TAG_W-1:0] tag_i,
  output logic [XLEN-1:0]  res_o,
  output logic             res_valid_o,
  output logic [1:0]       carry_o,
  output logic [CTX_W-1:0] ctx_o,
  output logic [TAG_W-1:0] tag_o
);
  srm_op_e         op;
  logic [XLEN-1:0] shl_res, ext_res, shr_res, rot_res;
  logic            sra_carry;

  assign op = srm_op_e'(op_i);

  srm_shift_path #(.XLEN(XLEN), .AW(AW), .AMT_W(AMT_W)) u_shift (
    .op_i       (op),
    .word_mode_i(word_mode_i),
    .signed_i   (signed_i),
    .rs_i       (rs_i),
    .amt_i      (rb_i),
    .shl_res_o  (shl_res),
    .ext_res_o  (ext_res),
    .shr_res_o  (shr_res),
    .sra_carry_o(sra_carry)
  );

  srm_rot_path #(.XLEN(XLEN), .AW(AW), .AMT_W(AMT_W)) u_rot (
    .op_i     (op),
    .rs_i     (rs_i),
    .ra_i     (ra_i),
    .amt_i    (rb_i),
    .mb_i     (mb_i),
    .me_i     (me_i),
    .rot_res_o(rot_res)
  );

  always_comb begin
    res_valid_o = op_supported(op);
    carry_o     = 2'b00;
    unique case (op)
      OP_SHL:    res_o = shl_res;
      OP_EXTSH:  res_o = ext_res;
      OP_SHR: begin
        res_o   = shr_res;
        carry_o = {2{sra_carry}};
      end
      OP_ROT32, OP_ROTINS, OP_ROTCLR: res_o = rot_res;
      default:   res_o = '0;
    endcase
  end

  assign ctx_o = ctx_i;
  assign tag_o = tag_i;
endmodule

// File: rtl/srm_unit_chk.sv
module srm_unit_chk
  import srm_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int CTX_W = 8,
  parameter int TAG_W = 2,
  parameter int AW    = $clog2(XLEN),
  parameter int AMT_W = AW + 1
) (
  input logic [2:0]       op_i,
  input logic             word_mode_i,
  input logic             signed_i,
  input logic [XLEN-1:0]  rs_i,
  input logic [AMT_W-1:0] rb_i,
  input logic [CTX_W-1:0] ctx_i,
  input logic [TAG_W-1:0] tag_i,
  input logic [XLEN-1:0]  res_o,
  input logic             res_valid_o,
  input logic [1:0]       carry_o,
  input logic [CTX_W-1:0] ctx_o,
  input logic [TAG_W-1:0] tag_o
);
  localparam int HALF = XLEN / 2;

  always_comb begin
    if (!$isunknown({op_i, word_mode_i, signed_i, rs_i, rb_i, ctx_i, tag_i})) begin
      AST_CTX_PASS: assert ({ctx_o, tag_o} == {ctx_i, tag_i})
        else $error("context not passed through"); // R10
      AST_CARRY_PAIR: assert (carry_o[0] == carry_o[1])
        else $error("carry bits differ"); // R4
      AST_CARRY_ONLY_SRA: assert (carry_o == 2'b00 || (op_i == OP_SHR && signed_i))
        else $error("carry outside arithmetic shift"); // R4
      AST_CARRY_NEG: assert (carry_o == 2'b00 || (word_mode_i ? rs_i[HALF-1] : rs_i[XLEN-1]))
        else $error("carry on non-negative operand"); // R4
      AST_INVALID_ZERO: assert (res_valid_o || (res_o == '0 && carry_o == 2'b00))
        else $error("unsupported op drives data"); // R11
      AST_SHL_WORD_HI: assert (!(op_i == OP_SHL && word_mode_i) || res_o[XLEN-1:HALF] == '0)
        else $error("word left shift upper half"); // R1
      AST_SRA_WORD_EXT: assert (!(op_i == OP_SHR && signed_i && word_mode_i)
                                || res_o[XLEN-1:HALF-1] == {(HALF+1){res_o[HALF-1]}}
                                || res_o[XLEN-1:HALF-1] == '0)
        else $error("word arithmetic shift not sign-extended"); // R3
    end
  end
endmodule

bind srm_unit srm_unit_chk #(.XLEN(XLEN), .CTX_W(CTX_W), .TAG_W(TAG_W), .AW(AW), .AMT_W(AMT_W)) u_chk (
  .op_i       (op_i),
  .word_mode_i(word_mode_i),
  .signed_i   (signed_i),
  .rs_i       (rs_i),
  .rb_i       (rb_i),
  .ctx_i      (ctx_i),
  .tag_i      (tag_i),
  .res_o      (res_o),
  .res_valid_o(res_valid_o),
  .carry_o    (carry_o),
  .ctx_o      (ctx_o),
  .tag_o      (tag_o)
);

// File: tb/srm_unit_tb.sv
module srm_unit_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic [2:0]  op_i = '0;
  logic        word_mode_i = 1'b0, signed_i = 1'b0;
  logic [63:0] rs_i = '0, ra_i = '0;
  logic [6:0]  rb_i = '0;
  logic [5:0]  mb_i = '0;
  logic [4:0]  me_i = '0;
  logic [7:0]  ctx_i = '0;
  logic [1:0]  tag_i = '0;
  logic [63:0] res_o;
  logic        res_valid_o;
  logic [1:0]  carry_o;
  logic [7:0]  ctx_o;
  logic [1:0]  tag_o;

  int checks = 0;
  int failures = 0;
  logic [63:0] rng = 64'h9E37_79B9_7F4A_7C15;

  always #(CLK_PERIOD/2) clk = ~clk;

  srm_unit dut_i (
    .op_i(op_i), .word_mode_i(word_mode_i), .signed_i(signed_i),
    .rs_i(rs_i), .rb_i(rb_i), .ra_i(ra_i), .mb_i(mb_i), .me_i(me_i),
    .ctx_i(ctx_i), .tag_i(tag_i), .res_o(res_o), .res_valid_o(res_valid_o),
    .carry_o(carry_o), .ctx_o(ctx_o), .tag_o(tag_o)
  );

  function automatic logic [63:0] next_rand();
    rng = rng ^ (rng << 13);
    rng = rng ^ (rng >> 7);
    rng = rng ^ (rng << 17);
    return rng;
  endfunction

  function automatic logic [63:0] be_mask(int b, int e);
    logic [63:0] m = '0;
    for (int p = 0; p < 64; p++) begin
      bit hit = (b <= e) ? (p >= b && p <= e) : (p >= b || p <= e);
      if (hit) m[63-p] = 1'b1;
    end
    return m;
  endfunction

  function automatic logic [63:0] rotl(logic [63:0] x, int k);
    return (k == 0) ? x : ((x << k) | (x >> (64 - k)));
  endfunction

  // Reference model; returns {carry, result}
  function automatic logic [64:0] model(int op, bit wm, bit sg, logic [63:0] rs,
                                        int amt, logic [63:0] ra, int mb, int me);
    logic [63:0] r = '0;
    bit c = 0;
    int a6 = amt % 64;
    case (op)
      1: if (wm) r = (a6 >= 32) ? 64'd0 : ((rs << a6) & 64'hFFFF_FFFF);
         else    r = (amt >= 64) ? 64'd0 : (rs << amt);
      2: if (!sg) begin
           if (wm) r = (a6 >= 32) ? 64'd0 : ({32'd0, rs[31:0]} >> a6);
           else    r = (amt >= 64) ? 64'd0 : (rs >> amt);
         end else if (wm) begin
           logic signed [31:0] s = rs[31:0];
           logic [31:0] v = (a6 >= 32) ? {32{s[31]}} : 32'(s >>> a6);
           r = {{32{v[31]}}, v};
           c = s[31] && ((a6 >= 32) || ((rs[31:0] & ((32'h1 << a6) - 1)) != 0));
         end else begin
           logic signed [63:0] s = rs;
           r = (amt >= 64) ? {64{rs[63]}} : 64'(s >>> amt);
           c = rs[63] && ((amt >= 64) || ((rs & ((64'h1 << amt) - 1)) != 0));
         end
      3: r = {{32{rs[31]}}, rs[31:0]} << a6;
      4: begin
           logic [63:0] m = be_mask((mb % 32) + 32, me + 32);
           r = (rotl({rs[31:0], rs[31:0]}, amt % 32) & m) | (ra & ~m);
         end
      5: begin
           int b = ((mb & 1) * 32) + (mb / 2);
           logic [63:0] m = be_mask(b, 63 - a6);
           r = (rotl(rs, a6) & m) | (ra & ~m);
         end
      6: begin
           int b = ((mb & 1) * 32) + (mb / 2);
           r = rotl(rs, a6) & be_mask(b, 63);
         end
      default: r = '0;
    endcase
    return {c, r};
  endfunction

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h (op=%0d wm=%0b sg=%0b rs=%h rb=%0d mb=%0d me=%0d)",
               req, got, exp, op_i, word_mode_i, signed_i, rs_i, rb_i, mb_i, me_i);
    end
  endtask

  task automatic apply(int op, bit wm, bit sg, logic [63:0] rs, int amt,
                       logic [63:0] ra, int mb, int me);
    @(posedge clk);
    #1;
    op_i = op[2:0]; word_mode_i = wm; signed_i = sg; rs_i = rs;
    rb_i = amt[6:0]; ra_i = ra; mb_i = mb[5:0]; me_i = me[4:0];
    ctx_i = 8'(next_rand()); tag_i = 2'(next_rand());
    @(negedge clk);
  endtask

  function automatic string res_tag(int op, bit sg);
    case (op)
      1: return "R1";
      2: return sg ? "R3" : "R2";
      3: return "R9";
      4: return "R6";
      5: return "R7";
      6: return "R8";
      default: return "R11";
    endcase
  endfunction

  task automatic run_vec(int op, bit wm, bit sg, logic [63:0] rs, int amt,
                         logic [63:0] ra, int mb, int me);
    logic [64:0] e;
    apply(op, wm, sg, rs, amt, ra, mb, me);
    e = model(op, wm, sg, rs, amt, ra, mb, me);
    chk(res_tag(op, sg), res_o, e[63:0]);
    chk("R4 carry", {62'd0, carry_o}, {62'd0, {2{e[64]}}});
    chk("R11 valid", {63'd0, res_valid_o}, {63'd0, (op >= 1 && op <= 6)});
    chk("R10 ctx", {54'd0, ctx_o, tag_o}, {54'd0, ctx_i, tag_i});
  endtask

  initial begin
    int amts[9] = '{0, 1, 31, 32, 33, 63, 64, 65, 127};
    logic [63:0] pats[8] = '{64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0001,
                             64'h0000_0000_8000_0001, 64'h0123_4567_89AB_CDEF,
                             64'hFEDC_BA98_7654_3210, 64'h7FFF_FFFF_0000_0000,
                             64'h0000_0001_7FFF_FFFF};
    // idle state: op 0 gives nothing (R11)
    apply(0, 0, 0, 64'hDEAD_BEEF_DEAD_BEEF, 5, 64'h1234, 3, 4);
    chk("R11 idle result", res_o, 64'd0);
    chk("R11 idle valid", {63'd0, res_valid_o}, 64'd0);

    for (int op = 0; op < 8; op++)
      for (int wm = 0; wm < 2; wm++)
        for (int sg = 0; sg < 2; sg++)
          for (int ai = 0; ai < 9; ai++)
            for (int di = 0; di < 8; di++) begin
              logic [63:0] ra = next_rand();
              logic [63:0] mr = next_rand();
              run_vec(op, wm[0], sg[0], pats[di], amts[ai], ra, int'(mr[5:0]), int'(mr[12:8]));
            end

    // random operands, random amounts
    for (int n = 0; n < 600; n++) begin
      logic [63:0] x = next_rand();
      logic [63:0] y = next_rand();
      logic [63:0] z = next_rand();
      run_vec(int'(z[2:0]), z[3], z[4], x, int'(z[14:8]), y, int'(z[21:16]), int'(z[28:24]));
    end

    // R5: raw word masks, every begin/end pair incl. wrap and begin=end+1
    for (int b = 0; b < 32; b++)
      for (int e = 0; e < 32; e++) begin
        apply(4, 0, 0, '1, 0, 64'd0, b, e);
        chk("R5 word mask", res_o, be_mask(b + 32, e + 32));
      end
    // R5: raw doubleword masks via rotate-clear, every begin field
    for (int mb = 0; mb < 64; mb++) begin
      apply(6, 0, 0, '1, 0, 64'hFFFF_FFFF_FFFF_FFFF, mb, 0);
      chk("R5 dword mask", res_o, be_mask(((mb & 1) * 32) + (mb / 2), 63));
    end
    // R8: ra has no effect on rotate-clear
    apply(6, 0, 0, 64'h0F0F_0000_0000_00F0, 4, 64'hFFFF_FFFF_FFFF_FFFF, 2, 0);
    chk("R8 ra ignored", res_o, rotl(64'h0F0F_0000_0000_00F0, 4) & be_mask(1, 63));
    // R4: lone low bit just shifted out of negative word operand
    apply(2, 1, 1, 64'h0000_0000_8000_0001, 1, 64'd0, 0, 0);
    chk("R4 lone bit carry", {62'd0, carry_o}, 64'd3);
    apply(2, 1, 1, 64'h0000_0000_8000_0002, 1, 64'd0, 0, 0);
    chk("R4 no lost bit", {62'd0, carry_o}, 64'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 190000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule